// File: doc/BRIEF.md
# ADC Power-Down Conversion Sequencer

This block runs periodic conversions on a serial analog-to-digital converter that is kept in its automatic power-down mode. A cycle timer, counting system clock ticks, sets the throughput. On each timer expiry the block raises the convert-start strobe. The strobe stays high for a programmed number of ticks so that a single pulse covers the converter's wake-up time and also starts the sample. The block then follows the converter's busy line. Busy passes through a two-stage synchronizer before any logic uses it.

When busy has risen and fallen again, the block raises a read request to a separate serial readout engine. It holds that request until the engine reports done. The converter returns to power-down by itself after each conversion, so a longer cycle keeps it asleep for a larger part of the period.

The block has two fault paths. A timer expiry that comes before the previous readout has finished is held as pending and reported as an overrun, and the next strobe waits for the done report. If busy does not rise, or does not fall, within a timeout window that opens when the strobe ends, the block reports a busy error, skips the readout and returns to idle. Both reports are single-cycle pulses.

Top module: `adc_pd_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it, convst, rd_req, overrun and busy_err are all 0.
- R2: While enable is 0 the cycle timer holds at zero and no strobe is issued. After enable is sampled high, the first strobe rises exactly CYCLE_TICKS clock edges later, and later timer expiries fall every CYCLE_TICKS edges on that same grid.
- R3: convst (active high) stays high for exactly STROBE_TICKS consecutive cycles per conversion.
- R4: When each readout finishes before the next timer expiry, consecutive strobe rising edges are exactly CYCLE_TICKS cycles apart.
- R5: busy_in goes through a two-stage synchronizer. rd_req rises on the third clock edge after busy_in falls, and it never rises while the synchronized busy is high.
- R6: rd_req stays high until rd_done is sampled high, and falls on that same edge. rd_done has no effect outside a readout.
- R7: A timer expiry that arrives when the sequencer is not idle produces a one-cycle overrun pulse and is held as pending. No strobe is issued while rd_req is high. The pending strobe rises on the second edge after rd_done is sampled.
- R8: A timer expiry in the same cycle as rd_done counts as an overrun, and the strobe follows one cycle later. If rd_done comes one cycle before the expiry, there is no overrun and the strobe rises on the expiry edge.
- R9: If synchronized busy does not rise within BUSY_TIMEOUT cycles after the strobe ends, busy_err pulses for one cycle exactly BUSY_TIMEOUT edges after the strobe's falling edge, no rd_req is raised, and the sequencer returns to idle.
- R10: The timeout window also covers a busy that rises but never falls. The error timing is the same as in R9, the readout is skipped, and later conversions proceed normally once busy is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the cycle timer; 0 stops periodic conversions |
| busy_in | input | 1 | Converter busy line, asynchronous |
| rd_done | input | 1 | Readout engine reports the result has been shifted out |
| convst | output | 1 | Convert-start strobe, active high, stretched to cover wake-up |
| rd_req | output | 1 | Request to the readout engine, held until rd_done |
| overrun | output | 1 | One-cycle pulse: timer expired before the previous readout finished |
| busy_err | output | 1 | One-cycle pulse: busy did not rise or fall within the timeout |

## Verification
Two functions can land on the same clock edge: the cycle timer's expiry and the readout engine's done report. The bench places both on one edge, using the expiry grid that R2 derives from the cycle in which enable was raised. It then checks that an overrun pulse appears and that the strobe rises one cycle late. As a contrast, it also moves rd_done one cycle earlier and checks that there is no overrun and that the strobe rises exactly on the grid edge.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_STROBE,
        SQ_WAIT_RISE,
        SQ_WAIT_FALL,
        SQ_READ
    } seq_state_e;

    typedef struct packed {
        logic overrun;
        logic busy_err;
    } seq_flags_t;

    // bit width able to hold values 0 .. n-1 (at least 1)
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/adc_busy_sync.sv
`timescale 1ns/1ps
module adc_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/adc_cycle_timer.sv
`timescale 1ns/1ps
module adc_cycle_timer
    import adc_seq_pkg::*;
#(
    parameter int CYCLE_TICKS = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = cnt_bits(CYCLE_TICKS);
    localparam logic [CW-1:0] LAST = CW'(CYCLE_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int STROBE_TICKS = 250,
    parameter int BUSY_TIMEOUT = 1250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       tick,
    input  logic       busy_s,
    input  logic       rd_done,
    output logic       convst,
    output logic       rd_req,
    output seq_flags_t flags
);
    localparam int SW = cnt_bits(STROBE_TICKS);
    localparam int TW = cnt_bits(BUSY_TIMEOUT + 1);
    localparam logic [SW-1:0] S_LAST = SW'(STROBE_TICKS - 1);
    localparam logic [TW-1:0] T_LAST = TW'(BUSY_TIMEOUT - 1);

    seq_state_e    state_q;
    logic [SW-1:0] scnt_q;
    logic [TW-1:0] tcnt_q;
    logic          pending_q;
    seq_flags_t    flags_q;
    logic          t_expired;

    assign t_expired = (tcnt_q >= T_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            scnt_q    <= '0;
            tcnt_q    <= '0;
            pending_q <= 1'b0;
            flags_q   <= '0;
        end else begin
            flags_q <= '0;

            // expiry while a conversion is still in flight
            if (tick && state_q != SQ_IDLE) begin
                flags_q.overrun <= 1'b1;
                pending_q       <= 1'b1;
            end

            case (state_q)
                SQ_IDLE: begin
                    if (enable && (tick || pending_q)) begin
                        state_q   <= SQ_STROBE;
                        scnt_q    <= '0;
                        pending_q <= 1'b0;
                    end
                end
                SQ_STROBE: begin
                    if (scnt_q == S_LAST) begin
                        state_q <= SQ_WAIT_RISE;
                        tcnt_q  <= '0;
                    end else begin
                        scnt_q <= scnt_q + 1'b1;
                    end
                end
                SQ_WAIT_RISE: begin
                    if (busy_s) begin
                        state_q <= SQ_WAIT_FALL;
                        tcnt_q  <= tcnt_q + 1'b1;
                    end else if (t_expired) begin
                        state_q          <= SQ_IDLE;
                        flags_q.busy_err <= 1'b1;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                SQ_WAIT_FALL: begin
                    if (!busy_s) begin
                        state_q <= SQ_READ;
                    end else if (t_expired) begin
                        state_q          <= SQ_IDLE;
                        flags_q.busy_err <= 1'b1;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                SQ_READ: begin
                    if (rd_done) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase

            if (!enable) pending_q <= 1'b0;
        end
    end

    always_comb begin
        convst = (state_q == SQ_STROBE);
        rd_req = (state_q == SQ_READ);
        flags  = flags_q;
    end
endmodule

// File: rtl/adc_pd_sequencer.sv
`timescale 1ns/1ps
module adc_pd_sequencer
    import adc_seq_pkg::*;
#(
    parameter int CYCLE_TICKS  = 12500,
    parameter int STROBE_TICKS = 250,
    parameter int BUSY_TIMEOUT = 1250,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic busy_in,
    input  logic rd_done,
    output logic convst,
    output logic rd_req,
    output logic overrun,
    output logic busy_err
);
    logic       busy_s;
    logic       tick;
    seq_flags_t flags;

    adc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (busy_in),
        .dout (busy_s)
    );

    adc_cycle_timer #(.CYCLE_TICKS(CYCLE_TICKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (enable),
        .tick (tick)
    );

    adc_seq_fsm #(
        .STROBE_TICKS (STROBE_TICKS),
        .BUSY_TIMEOUT (BUSY_TIMEOUT)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .tick    (tick),
        .busy_s  (busy_s),
        .rd_done (rd_done),
        .convst  (convst),
        .rd_req  (rd_req),
        .flags   (flags)
    );

    assign overrun  = flags.overrun;
    assign busy_err = flags.busy_err;
endmodule

// File: rtl/adc_pd_sequencer_chk.sv
`timescale 1ns/1ps
module adc_pd_sequencer_chk #(
    parameter int STROBE_TICKS = 250
) (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic busy_s,
    input logic rd_done,
    input logic convst,
    input logic rd_req,
    input logic overrun,
    input logic busy_err
);
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst)         run_q <= 0;
        else if (convst) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    // R1: quiet outputs during reset
    always_comb begin
        if (rst) a_r1_reset_quiet: assert (!convst && !rd_req && !overrun && !busy_err);
    end

    a_r2_strobe_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(convst) |-> $past(enable));

    a_r3_strobe_not_longer: assert property (@(posedge clk) disable iff (rst)
        convst |-> (run_q < STROBE_TICKS));

    a_r3_strobe_exact: assert property (@(posedge clk) disable iff (rst)
        $fell(convst) |-> (run_q == STROBE_TICKS));

    a_r5_req_after_busy_low: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_req) |-> !$past(busy_s));

    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_done) |=> rd_req);

    a_r6_req_release: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_done) |=> !rd_req);

    a_r7_no_strobe_in_read: assert property (@(posedge clk) disable iff (rst)
        $onehot0({convst, rd_req}));

    a_r9_err_skips_read: assert property (@(posedge clk) disable iff (rst)
        busy_err |-> (!rd_req && !convst));
endmodule

bind adc_pd_sequencer adc_pd_sequencer_chk #(.STROBE_TICKS(STROBE_TICKS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .busy_s   (busy_s),
    .rd_done  (rd_done),
    .convst   (convst),
    .rd_req   (rd_req),
    .overrun  (overrun),
    .busy_err (busy_err)
);

// File: tb/adc_pd_sequencer_test.sv
`timescale 1ns/1ps
module adc_pd_sequencer_test;
    localparam int C = 60;
    localparam int S = 5;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic busy_in = 1'b0;
    logic rd_done = 1'b0;
    logic convst, rd_req, overrun, busy_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int e0 = 0;
    int last_rise = -1;
    int prev_rise = -1;
    int n_rise = 0;
    int n_ovr = 0;
    int n_err = 0;
    int n_req = 0;
    int busy_mode = 0;   // 0 normal, 1 never rises, 2 stuck high
    logic cv_d = 1'b0;
    logic rq_d = 1'b0;
    bit finished = 0;

    adc_pd_sequencer #(
        .CYCLE_TICKS(C), .STROBE_TICKS(S), .BUSY_TIMEOUT(T), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst(rst), .enable(enable), .busy_in(busy_in), .rd_done(rd_done),
        .convst(convst), .rd_req(rd_req), .overrun(overrun), .busy_err(busy_err)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // observation at the falling edge
    always @(negedge clk) begin
        if (convst && !cv_d) begin
            prev_rise = last_rise;
            last_rise = cyc;
            n_rise++;
        end
        if (rd_req && !rq_d) n_req++;
        if (overrun)  n_ovr++;
        if (busy_err) n_err++;
        cv_d = convst;
        rq_d = rd_req;
    end

    // converter busy model, reacting to the strobe's falling edge
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (prev && !convst) begin
                if (busy_mode == 0) begin
                    repeat (2) @(negedge clk);
                    busy_in = 1'b1;
                    repeat (8) @(negedge clk);
                    busy_in = 1'b0;
                end else if (busy_mode == 2) begin
                    busy_in = 1'b1;
                end
            end
            prev = convst;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_rise();
        int g = 0;
        while (!convst && g < 2000) begin step(); g++; end
    endtask

    task automatic wait_fall(output int f);
        int g = 0;
        while (!convst && g < 2000) begin step(); g++; end
        while (convst && g < 4000) begin step(); g++; end
        f = cyc;
    endtask

    task automatic wait_req();
        int g = 0;
        while (!rd_req && g < 2000) begin step(); g++; end
    endtask

    task automatic give_done();
        rd_done = 1'b1;
        step();
        rd_done = 1'b0;
    endtask

    function automatic int next_tick();
        return e0 + ((cyc - e0) / C + 1) * C;
    endfunction

    task automatic t_reset();
        repeat (3) step();
        chk("R1 convst in reset", convst, 0);
        chk("R1 rd_req in reset", rd_req, 0);
        rst = 1'b0;
        step();
        chk("R1 overrun after reset", overrun, 0);
        chk("R1 busy_err after reset", busy_err, 0);
    endtask

    task automatic t_disabled();
        int r0 = n_rise;
        repeat (3 * C) step();
        chk("R2 no strobe while disabled", n_rise - r0, 0);
    endtask

    task automatic t_first_conversion();
        int g = 0;
        enable = 1'b1;
        e0 = cyc;
        wait_rise();
        chk("R2 first strobe delay", last_rise - e0, C);
        while (convst && g < 100) begin step(); g++; end
        chk("R3 strobe width", cyc - last_rise, S);
        g = 0;
        while (!busy_in && g < 100) begin step(); g++; end
        chk("R5 no request while busy", rd_req, 0);
        while (busy_in && g < 200) begin step(); g++; end
        step(); step();
        chk("R5 request not yet after two edges", rd_req, 0);
        step();
        chk("R5 request on third edge", rd_req, 1);
        repeat (10) step();
        chk("R6 request held without done", rd_req, 1);
        give_done();
        chk("R6 request released", rd_req, 0);
        wait_rise();
        chk("R4 strobe period", last_rise - prev_rise, C);
    endtask

    task automatic t_overrun();
        int o0;
        int g = 0;
        wait_req();
        o0 = n_ovr;
        while (cyc < last_rise + C + 3 && g < 500) begin step(); g++; end
        chk("R7 overrun pulse count", n_ovr - o0, 1);
        chk("R7 no strobe while reading", convst, 0);
        chk("R7 request still high", rd_req, 1);
        give_done();
        chk("R7 idle cycle after done", convst, 0);
        step();
        chk("R7 pending strobe after done", convst, 1);
    endtask

    task automatic t_same_cycle();
        int t;
        int o0;
        int g = 0;
        wait_req();
        t = next_tick();
        while (cyc < t - 1 && g < 500) begin step(); g++; end
        o0 = n_ovr;
        rd_done = 1'b1;
        step();
        rd_done = 1'b0;
        chk("R8 same-cycle done counts as overrun", n_ovr - o0, 1);
        chk("R8 strobe not on expiry edge", convst, 0);
        step();
        chk("R8 strobe one cycle late", last_rise, t + 1);
    endtask

    task automatic t_early_done();
        int t;
        int o0;
        int g = 0;
        wait_req();
        t = next_tick();
        while (cyc < t - 2 && g < 500) begin step(); g++; end
        o0 = n_ovr;
        give_done();
        step();
        chk("R8 no overrun when done is early", n_ovr - o0, 0);
        chk("R8 strobe on expiry edge", last_rise, t);
    endtask

    task automatic t_no_rise();
        int f;
        int e;
        int q0;
        int g = 0;
        busy_mode = 1;
        q0 = n_req;
        e = n_err;
        wait_fall(f);
        while (n_err == e && g < 500) begin step(); g++; end
        chk("R9 error delay after strobe", cyc - f, T);
        repeat (3) step();
        chk("R9 readout skipped", n_req - q0, 0);
        busy_mode = 0;
    endtask

    task automatic t_stuck_busy();
        int f;
        int e;
        int q0;
        int g = 0;
        busy_mode = 2;
        q0 = n_req;
        e = n_err;
        wait_fall(f);
        while (n_err == e && g < 500) begin step(); g++; end
        chk("R10 error delay with stuck busy", cyc - f, T);
        busy_in = 1'b0;
        busy_mode = 0;
        repeat (4) step();
        chk("R10 readout skipped", n_req - q0, 0);
        wait_req();
        chk("R10 recovery conversion reaches readout", rd_req, 1);
        give_done();
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_first_conversion();
        t_overrun();
        t_same_cycle();
        t_early_done();
        t_no_rise();
        t_stuck_busy();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule